// File: doc/BRIEF.md
# Character LCD hex display controller

This block drives a character LCD that has an 8-bit parallel bus. After reset it waits for the panel to power up. It then sends a fixed list of setup instructions, each followed by a settling delay. Once that is done, it accepts 16-bit values on a valid/ready handshake. Each value appears on the panel as four uppercase ASCII hexadecimal characters, with the most significant nibble first.

Every transfer to the panel is a write. The register-select line marks whether the byte is an instruction or a character, and the read/write line stays low. The enable strobe is a pulse of fixed width. The byte and the select line are set up one cycle before the pulse and held until after it. The block never polls the busy flag. Instead, a down-counter sized from the `CLK_HZ` parameter inserts a fixed wait after every write. A small `CLK_HZ` shrinks every wait in proportion, which is how the bench keeps its runs short.

Top module: `hexlcd_ctrl`

## Requirements
- R1: `lcd_rw_o` is 0 at all times. `lcd_rs_o` is 0 during every instruction write and 1 during every character write.
- R2: After reset is released, `in_ready_o` stays 0 and no enable pulse appears for at least 30 ms of clock cycles (30*CLK_HZ/1000).
- R3: The first four writes after reset are instructions, in this order: 0x3C, 0x0F, 0x01, 0x06.
- R4: Each write raises `lcd_e_o` for exactly 7 consecutive cycles. `lcd_data_o` and `lcd_rs_o` hold one value from the cycle before `lcd_e_o` rises through the cycle after it falls.
- R5: Between the fall of one pulse and the rise of the next, `lcd_e_o` stays low for at least the wait owed to the earlier write: 1 ms after an instruction, 2 ms after the clear instruction 0x01, and 30 ms after a character.
- R6: A nibble n becomes the byte 0x30+n for n of 0 to 9, and 0x37+n for n of 10 to 15. This gives the ASCII characters '0'-'9' and 'A'-'F'.
- R7: An accepted value is sent as exactly four characters, taken from bits 15:12, then 11:8, then 7:4, then 3:0.
- R8: `in_ready_o` is 1 only when init has finished and no value is in progress. A value is taken when `in_valid_i` and `in_ready_o` are both 1 on a clock edge, and `in_ready_o` drops on the next cycle. `in_valid_i` has no effect while `in_ready_o` is 0.
- R9: Asserting `rst_ni` in the middle of a value abandons that value. The block restarts from the power-up wait and the full init sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | 1 | A value is offered on in_data_i |
| in_data_i | input | 16 | Value to display |
| in_ready_o | output | 1 | Block can take a value |
| lcd_rs_o | output | 1 | Register select: 0 instruction, 1 character |
| lcd_rw_o | output | 1 | Read/write select, always 0 (write) |
| lcd_e_o | output | 1 | Enable strobe |
| lcd_data_o | output | 8 | Byte on the panel bus |

## Verification
Assertions check these properties on every cycle:
- The bus and the select line stay stable around each enable pulse.
- Every pulse is exactly seven cycles wide.
- No write starts while a delay is still counting.
- `in_ready_o` never coincides with a pulse, and it drops after an acceptance.
- Instruction bytes come only from the init set, and character bytes are always valid hex ASCII.

Only the bench scenarios can show the actual order of the init instructions, the lengths of the delays, the exact characters and their digit order for a given value, that offers made during a busy period are ignored, and that the sequence restarts after a reset in mid-value.

// File: rtl/hexlcd_pkg.sv
package hexlcd_pkg;

  typedef enum logic [1:0] {WS_IDLE, WS_SETUP, WS_PULSE, WS_DONE} wr_state_e;
  typedef enum logic [2:0] {SQ_PWR, SQ_ISSUE, SQ_WAIT, SQ_DLY, SQ_IDLE} seq_state_e;

  localparam int unsigned N_INIT   = 4;
  localparam int unsigned N_DIGITS = 4;
  localparam int unsigned IDX_W    = 2;

  // power-up instruction list; index 2 is the clear
  function automatic logic [7:0] init_cmd(input logic [IDX_W-1:0] idx);
    case (idx)
      2'd0:    return 8'h3C;
      2'd1:    return 8'h0F;
      2'd2:    return 8'h01;
      default: return 8'h06;
    endcase
  endfunction

  function automatic logic [7:0] nib_ascii(input logic [3:0] n);
    if (n > 4'd9) return {4'h0, n} + 8'h37;
    else          return {4'h0, n} + 8'h30;
  endfunction

endpackage

// File: rtl/hexlcd_strobe.sv
module hexlcd_strobe
  import hexlcd_pkg::*;
#(
  parameter int unsigned E_HIGH = 7
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       start_i,
  input  logic       rs_i,
  input  logic [7:0] byte_i,
  output logic       done_o,
  output logic       lcd_rs_o,
  output logic       lcd_e_o,
  output logic [7:0] lcd_data_o
);
  localparam int unsigned CW = $clog2(E_HIGH + 1);

  wr_state_e     state_q;
  logic [CW-1:0] cnt_q;
  logic          rs_q;
  logic [7:0]    data_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= WS_IDLE;
      cnt_q   <= '0;
      rs_q    <= 1'b0;
      data_q  <= '0;
    end else begin
      case (state_q)
        WS_IDLE: if (start_i) begin
          rs_q    <= rs_i;
          data_q  <= byte_i;
          state_q <= WS_SETUP;
        end
        WS_SETUP: begin
          cnt_q   <= '0;
          state_q <= WS_PULSE;
        end
        WS_PULSE: begin
          if (cnt_q == CW'(E_HIGH - 1)) state_q <= WS_DONE;
          else                          cnt_q   <= cnt_q + 1'b1;
        end
        default: state_q <= WS_IDLE;
      endcase
    end
  end

  assign lcd_e_o    = (state_q == WS_PULSE);
  assign done_o     = (state_q == WS_DONE);
  assign lcd_rs_o   = rs_q;
  assign lcd_data_o = data_q;

  // checker: independent width counter
  logic [CW-1:0] hi_cnt_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      hi_cnt_q <= '0;
    else if (lcd_e_o) hi_cnt_q <= hi_cnt_q + 1'b1;
    else              hi_cnt_q <= '0;
  end

  a_r4_bus_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lcd_e_o || $past(lcd_e_o)) |-> $stable({lcd_rs_o, lcd_data_o}));

  a_r4_pulse_width: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(lcd_e_o) |-> (hi_cnt_q == CW'(E_HIGH)));

  a_r4_pulse_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lcd_e_o |-> (hi_cnt_q < CW'(E_HIGH)));

endmodule

// File: rtl/hexlcd_delay.sv
module hexlcd_delay #(
  parameter int unsigned TW        = 8,
  parameter int unsigned RESET_VAL = 10
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [TW-1:0] val_i,
  output logic          zero_o
);
  logic [TW-1:0] cnt_q;

  // reset value doubles as the power-up wait
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cnt_q <= TW'(RESET_VAL);
    else if (load_i)        cnt_q <= val_i;
    else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
  end

  assign zero_o = (cnt_q == '0);

endmodule

// File: rtl/hexlcd_seq.sv
module hexlcd_seq
  import hexlcd_pkg::*;
#(
  parameter int unsigned TW        = 8,
  parameter int unsigned CMD_TICKS = 10,
  parameter int unsigned CLR_TICKS = 20,
  parameter int unsigned CHR_TICKS = 300
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          in_valid_i,
  input  logic [15:0]   in_data_i,
  output logic          in_ready_o,
  output logic          wr_start_o,
  output logic          wr_rs_o,
  output logic [7:0]    wr_byte_o,
  input  logic          wr_done_i,
  output logic          tmr_load_o,
  output logic [TW-1:0] tmr_val_o,
  input  logic          tmr_zero_i
);
  seq_state_e       state_q;
  logic [IDX_W-1:0] idx_q;
  logic             is_data_q;
  logic [15:0]      val_q;
  logic [3:0]       nib;

  localparam logic [IDX_W-1:0] LAST_INIT  = IDX_W'(N_INIT - 1);
  localparam logic [IDX_W-1:0] LAST_DIGIT = IDX_W'(N_DIGITS - 1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= SQ_PWR;
      idx_q     <= '0;
      is_data_q <= 1'b0;
      val_q     <= '0;
    end else begin
      case (state_q)
        SQ_PWR: if (tmr_zero_i) begin
          idx_q     <= '0;
          is_data_q <= 1'b0;
          state_q   <= SQ_ISSUE;
        end
        SQ_ISSUE: state_q <= SQ_WAIT;
        SQ_WAIT:  if (wr_done_i) state_q <= SQ_DLY;
        SQ_DLY: if (tmr_zero_i) begin
          if (idx_q == (is_data_q ? LAST_DIGIT : LAST_INIT)) begin
            idx_q   <= '0;
            state_q <= SQ_IDLE;
          end else begin
            idx_q   <= idx_q + 1'b1;
            state_q <= SQ_ISSUE;
          end
        end
        SQ_IDLE: if (in_valid_i) begin
          val_q     <= in_data_i;
          is_data_q <= 1'b1;
          idx_q     <= '0;
          state_q   <= SQ_ISSUE;
        end
        default: state_q <= SQ_PWR;
      endcase
    end
  end

  // most significant nibble first
  always_comb begin
    case (idx_q)
      2'd0:    nib = val_q[15:12];
      2'd1:    nib = val_q[11:8];
      2'd2:    nib = val_q[7:4];
      default: nib = val_q[3:0];
    endcase
  end

  assign in_ready_o = (state_q == SQ_IDLE);
  assign wr_start_o = (state_q == SQ_ISSUE);
  assign wr_rs_o    = is_data_q;
  assign wr_byte_o  = is_data_q ? nib_ascii(nib) : init_cmd(idx_q);
  assign tmr_load_o = (state_q == SQ_WAIT) && wr_done_i;

  always_comb begin
    if (is_data_q)          tmr_val_o = TW'(CHR_TICKS);
    else if (idx_q == 2'd2) tmr_val_o = TW'(CLR_TICKS);
    else                    tmr_val_o = TW'(CMD_TICKS);
  end

  a_r5_no_write_in_delay: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_start_o |-> tmr_zero_i);

  a_r8_accept_drops_ready: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_valid_i && in_ready_o) |=> !in_ready_o);

endmodule

// File: rtl/hexlcd_ctrl.sv
module hexlcd_ctrl
  import hexlcd_pkg::*;
#(
  parameter int unsigned CLK_HZ = 50_000_000,
  parameter int unsigned E_HIGH = 7,
  parameter int unsigned PWR_MS = 30,
  parameter int unsigned CMD_MS = 1,
  parameter int unsigned CLR_MS = 2,
  parameter int unsigned CHR_MS = 30
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        in_valid_i,
  input  logic [15:0] in_data_i,
  output logic        in_ready_o,
  output logic        lcd_rs_o,
  output logic        lcd_rw_o,
  output logic        lcd_e_o,
  output logic [7:0]  lcd_data_o
);
  localparam int unsigned TICKS_MS = CLK_HZ / 1000;
  localparam int unsigned PWR_T    = PWR_MS * TICKS_MS;
  localparam int unsigned CMD_T    = CMD_MS * TICKS_MS;
  localparam int unsigned CLR_T    = CLR_MS * TICKS_MS;
  localparam int unsigned CHR_T    = CHR_MS * TICKS_MS;
  localparam int unsigned MAX_A    = (PWR_T > CHR_T) ? PWR_T : CHR_T;
  localparam int unsigned MAX_B    = (CLR_T > CMD_T) ? CLR_T : CMD_T;
  localparam int unsigned MAX_T    = (MAX_A > MAX_B) ? MAX_A : MAX_B;
  localparam int unsigned TW       = $clog2(MAX_T + 1);

  logic          wr_start, wr_rs, wr_done;
  logic [7:0]    wr_byte;
  logic          tmr_load, tmr_zero;
  logic [TW-1:0] tmr_val;

  hexlcd_seq #(
    .TW(TW), .CMD_TICKS(CMD_T), .CLR_TICKS(CLR_T), .CHR_TICKS(CHR_T)
  ) u_seq (
    .clk_i, .rst_ni, .in_valid_i, .in_data_i, .in_ready_o,
    .wr_start_o(wr_start), .wr_rs_o(wr_rs), .wr_byte_o(wr_byte),
    .wr_done_i(wr_done), .tmr_load_o(tmr_load), .tmr_val_o(tmr_val),
    .tmr_zero_i(tmr_zero)
  );

  hexlcd_delay #(.TW(TW), .RESET_VAL(PWR_T)) u_delay (
    .clk_i, .rst_ni, .load_i(tmr_load), .val_i(tmr_val), .zero_o(tmr_zero)
  );

  hexlcd_strobe #(.E_HIGH(E_HIGH)) u_strobe (
    .clk_i, .rst_ni, .start_i(wr_start), .rs_i(wr_rs), .byte_i(wr_byte),
    .done_o(wr_done), .lcd_rs_o, .lcd_e_o, .lcd_data_o
  );

  assign lcd_rw_o = 1'b0;

  a_r3_instr_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lcd_e_o && !lcd_rs_o) |-> (lcd_data_o inside {8'h3C, 8'h0F, 8'h01, 8'h06}));

  a_r6_char_hex: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lcd_e_o && lcd_rs_o) |->
      ((lcd_data_o >= 8'h30 && lcd_data_o <= 8'h39) ||
       (lcd_data_o >= 8'h41 && lcd_data_o <= 8'h46)));

  a_r8_ready_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_ready_o |-> !lcd_e_o);

endmodule

// File: tb/hexlcd_ctrl_tb.sv
`timescale 1ns/1ps
module hexlcd_ctrl_tb;
  localparam int unsigned TB_HZ = 10_000;
  localparam int TMS   = TB_HZ / 1000;
  localparam int PWR_C = 30 * TMS;
  localparam int CMD_C = 1 * TMS;
  localparam int CLR_C = 2 * TMS;
  localparam int CHR_C = 30 * TMS;
  localparam int SLACK = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [15:0] in_data = '0;
  logic        in_ready, lcd_rs, lcd_rw, lcd_e;
  logic [7:0]  lcd_data;

  always #2.5 clk = ~clk;

  hexlcd_ctrl #(.CLK_HZ(TB_HZ)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .in_valid_i(in_valid), .in_data_i(in_data),
    .in_ready_o(in_ready), .lcd_rs_o(lcd_rs), .lcd_rw_o(lcd_rw),
    .lcd_e_o(lcd_e), .lcd_data_o(lcd_data)
  );

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 0;

  // captured writes
  logic       ent_rs   [0:63];
  logic [7:0] ent_data [0:63];
  int         ent_w    [0:63];
  int         ent_gap  [0:63];
  bit         ent_ok   [0:63];
  int         n_ent;
  bit         e_prev, cur_ok;
  logic [8:0] bus_prev;
  int         hi, lo, gap_cur;

  always @(negedge clk) begin
    if (!rst_n) begin
      n_ent = 0; e_prev = 0; hi = 0; lo = 0; cur_ok = 1;
      bus_prev = {lcd_rs, lcd_data};
    end else begin
      if (lcd_e && !e_prev) begin
        cur_ok  = ({lcd_rs, lcd_data} == bus_prev) && !lcd_rw;
        gap_cur = lo;
        hi      = 1;
      end else if (lcd_e) begin
        hi++;
        if ({lcd_rs, lcd_data} != bus_prev || lcd_rw) cur_ok = 0;
      end else if (e_prev) begin
        if ({lcd_rs, lcd_data} != bus_prev) cur_ok = 0;
        if (n_ent < 64) begin
          ent_rs[n_ent] = lcd_rs; ent_data[n_ent] = lcd_data;
          ent_w[n_ent] = hi; ent_gap[n_ent] = gap_cur; ent_ok[n_ent] = cur_ok;
          n_ent++;
        end
        lo = 1;
      end else lo++;
      e_prev   = lcd_e;
      bus_prev = {lcd_rs, lcd_data};
    end
  end

  task automatic check(input bit cond, input string req, input int act, input int exp);
    n_tests++;
    if (!cond) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_char(input logic [3:0] n);
    if (n < 4'd10) return 8'h30 + 8'(n);
    return 8'h41 + 8'(n - 4'd10);
  endfunction

  task automatic wait_entries(input int n);
    int t = 0;
    while (n_ent < n && t < 20000) begin @(negedge clk); t++; end
    check(n_ent >= n, "capture timeout", n_ent, n);
  endtask

  task automatic wait_ready();
    int t = 0;
    while (!in_ready && t < 20000) begin @(negedge clk); t++; end
    check(in_ready, "R8 ready timeout", in_ready, 1);
  endtask

  task automatic t_reset_state();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    check(!in_ready, "R2 ready in reset", in_ready, 0);
    check(!lcd_e,    "R2 e in reset", lcd_e, 0);
    check(!lcd_rw,   "R1 rw in reset", lcd_rw, 0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    check(!in_ready && !lcd_e, "R2 quiet after reset", {in_ready, lcd_e}, 0);
  endtask

  task automatic t_init();
    logic [7:0] cmds [4] = '{8'h3C, 8'h0F, 8'h01, 8'h06};
    int         dly  [4] = '{PWR_C, CMD_C, CMD_C, CLR_C};
    wait_entries(4);
    for (int i = 0; i < 4; i++) begin
      check(ent_rs[i] == 1'b0, "R1 instr rs", ent_rs[i], 0);
      check(ent_data[i] == cmds[i], "R3 init byte", ent_data[i], cmds[i]);
      check(ent_w[i] == 7, "R4 pulse width", ent_w[i], 7);
      check(ent_ok[i], "R4 bus stable / R1 rw", 0, 1);
      check(ent_gap[i] >= dly[i] && ent_gap[i] <= dly[i] + SLACK,
            (i == 0) ? "R2 power-up wait" : "R5 instr wait", ent_gap[i], dly[i]);
    end
    wait_ready();
    check(lo >= CMD_C, "R8 ready after last wait", lo, CMD_C);
  endtask

  task automatic send(input logic [15:0] v);
    wait_ready();
    in_valid = 1'b1; in_data = v;
    @(negedge clk);
    in_valid = 1'b0;
    check(!in_ready, "R8 ready drops after accept", in_ready, 0);
  endtask

  task automatic verify_value(input int base, input logic [15:0] v);
    logic [3:0] nibs [4];
    nibs = '{v[15:12], v[11:8], v[7:4], v[3:0]};
    wait_entries(base + 4);
    for (int i = 0; i < 4; i++) begin
      check(ent_rs[base+i] == 1'b1, "R1 data rs", ent_rs[base+i], 1);
      check(ent_data[base+i] == exp_char(nibs[i]), "R6 R7 char",
            ent_data[base+i], exp_char(nibs[i]));
      check(ent_w[base+i] == 7 && ent_ok[base+i], "R4 char strobe", ent_w[base+i], 7);
      if (i > 0)
        check(ent_gap[base+i] >= CHR_C && ent_gap[base+i] <= CHR_C + SLACK,
              "R5 char wait", ent_gap[base+i], CHR_C);
    end
  endtask

  task automatic t_value(input logic [15:0] v);
    int base;
    send(v);
    base = n_ent;
    verify_value(base, v);
  endtask

  task automatic t_ignore();
    int  base;
    bit  rdy_seen = 0;
    send(16'h1357);
    base = n_ent;
    in_valid = 1'b1; in_data = 16'hAAAA;
    for (int i = 0; i < 100; i++) begin
      @(negedge clk);
      if (in_ready) rdy_seen = 1;
    end
    in_valid = 1'b0;
    check(!rdy_seen, "R8 ready low while busy", rdy_seen, 0);
    verify_value(base, 16'h1357);
    wait_ready();
    repeat (400) @(negedge clk);
    check(n_ent == base + 4, "R8 busy offer ignored", n_ent, base + 4);
  endtask

  task automatic t_midreset();
    send(16'hC0DE);
    wait_entries(n_ent + 2);
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(!in_ready && n_ent == 0, "R9 restart clears progress", in_ready, 0);
    t_init();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++; n_tests++;
      $display("FAIL watchdog: actual 0 expected 1");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    t_reset_state();
    t_init();
    t_value(16'h1234);
    t_value(16'h9A0F);
    t_value(16'hFEDC);
    t_ignore();
    t_midreset();
    t_value(16'h5B6C);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule